// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a direct-mapped data cache. It uses write-back with allocation on writes. The processor side moves one 32-bit word per access. The memory side moves a whole 128-bit line per transfer.

Each of the 1024 lines holds four words. Each line also carries a valid flag, a dirty flag and an 18-bit tag. A four-state controller runs every access through these states:

- Idle.
- Lookup, where the tag is compared and the data is read or written in the same cycle.
- An optional eviction of a dirty victim line to memory.
- Refill of the new line from memory.

After a refill the controller returns to Lookup, and the access then completes as a hit.

The processor raises `cpu_valid` together with the address, direction and write data. It holds them until it sees `cpu_ready`. The memory side uses the same valid/ready pairing. Every memory transfer is a whole aligned line.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid and clean, `cpu_ready` and `mem_valid` are low, and the first access to any address causes a line fill from memory.
- R2: Address bits [31:14] form the tag, bits [13:4] select the line and bits [3:2] select the word within the line. Every memory address has bits [3:0] equal to zero.
- R3: A read hit returns the addressed word with `cpu_ready` high on the second rising edge after `cpu_valid` is seen in Idle, and it makes no memory request.
- R4: A write hit replaces only the addressed 32-bit word of its line, leaves the other three words unchanged, completes in the same time as a read hit, and marks the line dirty.
- R5: A miss on a clean or invalid line issues exactly one memory read (`mem_write` = 0) at {new tag, index, 0000} and no memory write.
- R6: A miss on a dirty line first issues one memory write (`mem_write` = 1) at {old tag, index, 0000} carrying the line's latest contents. The refill read follows it.
- R7: Once `mem_valid` rises, it stays high with a stable address and direction until `mem_ready` is sampled high.
- R8: `cpu_ready` is high for exactly one cycle per access and never while a memory request is pending.
- R9: After a refill the access completes as a hit. A read returns the refilled word, and a write merges its word into the refilled line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Word to write |
| cpu_rdata | output | 32 | Word read, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory line transfer request |
| mem_write | output | 1 | 1 = write back a line, 0 = fetch a line |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line sent to memory |
| mem_rdata | input | 128 | Line returned by memory |
| mem_ready | input | 1 | Memory transfer complete |

## Verification
The assertions assume three things about the environment:

- The processor keeps its request steady until `cpu_ready`.
- Memory answers every request eventually, with `mem_ready` as a one-cycle pulse.
- `mem_rdata` is valid in the cycle of that pulse.

The bench drives its inputs on falling edges. It holds each processor request until completion and drops `cpu_valid` on the falling edge where `cpu_ready` is seen. Its memory model raises `mem_ready` for exactly one cycle after a random delay of zero to three cycles. Random addresses are drawn from four tags, four lines and four words, so that evictions of dirty lines happen often.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    parameter int ADDR_W = 32;
    parameter int IDX_W  = 10;
    parameter int OFF_W  = 4;
    parameter int WORD_W = 32;

    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int SEL_W  = OFF_W - 2;
    localparam int WPL    = 1 << SEL_W;
    localparam int LINE_W = WORD_W * WPL;
    localparam int LINES  = 1 << IDX_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_REFILL
    } state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] sel;
    } req_addr_t;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
    } meta_t;

    function automatic logic [LINE_W-1:0] merge_word(
        input logic [LINE_W-1:0] line,
        input logic [SEL_W-1:0]  sel,
        input logic [WORD_W-1:0] w
    );
        logic [LINE_W-1:0] r;
        r = line;
        r[int'(sel)*WORD_W +: WORD_W] = w;
        return r;
    endfunction
endpackage

// File: rtl/dmc_meta_store.sv
module dmc_meta_store
    import dmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output meta_t            rd_meta,
    input  logic             we,
    input  meta_t            wr_meta
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // flags are cleared by reset; tags need no reset since valid gates them
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[idx] <= wr_meta.valid;
            dirty_q[idx] <= wr_meta.dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (we) tag_q[idx] <= wr_meta.tag;
    end

    assign rd_meta = '{valid: valid_q[idx], dirty: dirty_q[idx], tag: tag_q[idx]};
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              we,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (we) line_q[idx] <= wr_line;
    end

    assign rd_line = line_q[idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [IDX_W-1:0]  idx,
    input  meta_t             meta_rd,
    input  logic [LINE_W-1:0] line_rd,
    output logic              meta_we,
    output meta_t             meta_wr,
    output logic              data_we,
    output logic [LINE_W-1:0] data_wr
);
    state_e           state_q;
    req_addr_t        req_q;
    logic             req_wr_q;
    logic [WORD_W-1:0] req_data_q;
    logic [TAG_W-1:0] victim_tag_q;
    logic             hit;

    assign idx = req_q.idx;
    assign hit = meta_rd.valid && (meta_rd.tag == req_q.tag);
    assign cpu_rdata = line_rd[int'(req_q.sel)*WORD_W +: WORD_W];
    assign mem_wdata = line_rd;

    always_comb begin
        cpu_ready = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        meta_we   = 1'b0;
        meta_wr   = '{valid: 1'b0, dirty: 1'b0, tag: req_q.tag};
        data_we   = 1'b0;
        data_wr   = mem_rdata;
        unique case (state_q)
            ST_LOOKUP: begin
                if (hit) begin
                    cpu_ready = 1'b1;
                    if (req_wr_q) begin
                        data_we = 1'b1;
                        data_wr = merge_word(line_rd, req_q.sel, req_data_q);
                        meta_we = 1'b1;
                        meta_wr = '{valid: 1'b1, dirty: 1'b1, tag: req_q.tag};
                    end
                end else begin
                    meta_we = 1'b1;
                end
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {victim_tag_q, req_q.idx, {OFF_W{1'b0}}};
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                mem_addr  = {req_q.tag, req_q.idx, {OFF_W{1'b0}}};
                if (mem_ready) begin
                    data_we = 1'b1;
                    meta_we = 1'b1;
                    meta_wr = '{valid: 1'b1, dirty: 1'b0, tag: req_q.tag};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            req_q        <= '0;
            req_wr_q     <= 1'b0;
            req_data_q   <= '0;
            victim_tag_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cpu_valid) begin
                    req_q      <= cpu_addr[ADDR_W-1:2];
                    req_wr_q   <= cpu_write;
                    req_data_q <= cpu_wdata;
                    state_q    <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        state_q <= ST_IDLE;
                    end else begin
                        victim_tag_q <= meta_rd.tag;
                        state_q <= (meta_rd.valid && meta_rd.dirty) ? ST_EVICT : ST_REFILL;
                    end
                end
                ST_EVICT:  if (mem_ready) state_q <= ST_REFILL;
                ST_REFILL: if (mem_ready) state_q <= ST_LOOKUP;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)); // R7
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready); // R8
    AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_valid); // R8
    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_addr[OFF_W-1:0] == '0); // R2
    AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_write && mem_ready |=> mem_valid && !mem_write); // R6
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_write && mem_ready |=> cpu_ready); // R9
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    logic [IDX_W-1:0]  idx;
    meta_t             meta_rd, meta_wr;
    logic              meta_we, data_we;
    logic [LINE_W-1:0] line_rd, data_wr;

    dmc_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .idx(idx), .meta_rd(meta_rd), .line_rd(line_rd),
        .meta_we(meta_we), .meta_wr(meta_wr),
        .data_we(data_we), .data_wr(data_wr)
    );

    dmc_meta_store u_meta (
        .clk(clk), .rst(rst), .idx(idx), .rd_meta(meta_rd),
        .we(meta_we), .wr_meta(meta_wr)
    );

    dmc_data_store u_data (
        .clk(clk), .idx(idx), .rd_line(line_rd),
        .we(data_we), .wr_line(data_wr)
    );
endmodule

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_valid = 1'b0;
    logic         cpu_write = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         mem_valid, mem_write;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int n_wb = 0, n_fill = 0, seq = 0, wb_seq = 0, fill_seq = 0;
    logic [31:0] last_wb_addr = '0, last_fill_addr = '0;
    int wait_cnt = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [127:0] mem_blk [logic [31:0]];
    logic [31:0]  gold [logic [31:0]];

    always #2 clk = ~clk;

    dm_wb_cache u_dm_wb_cache (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'h5A17C3E5;
    endfunction

    function automatic logic [31:0] gold_word(input logic [31:0] a);
        logic [31:0] k = {a[31:2], 2'b00};
        return gold.exists(k) ? gold[k] : init_word(k);
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: one-cycle ready pulse after 0..3 idle cycles
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (!rst && mem_valid) begin
            if (wait_cnt == 0) begin
                seq++;
                chk("R2", {124'd0, mem_addr[3:0]}, 128'd0, "memory address alignment");
                if (mem_write) begin
                    n_wb++; wb_seq = seq; last_wb_addr = mem_addr;
                    for (int w = 0; w < 4; w++)
                        chk("R6", {96'd0, mem_wdata[w*32 +: 32]},
                            {96'd0, gold_word(mem_addr + 32'(w*4))}, "evicted word");
                    mem_blk[mem_addr] = mem_wdata;
                end else begin
                    n_fill++; fill_seq = seq; last_fill_addr = mem_addr;
                    if (mem_blk.exists(mem_addr)) mem_rdata = mem_blk[mem_addr];
                    else for (int w = 0; w < 4; w++)
                        mem_rdata[w*32 +: 32] = init_word(mem_addr + 32'(w*4));
                end
                mem_ready = 1'b1;
                wait_cnt = int'($urandom % 4);
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int lat);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
        lat = 0;
        while (!done) begin
            @(negedge clk);
            lat++;
            if (cpu_ready) break;
        end
        rd = cpu_rdata;
        cpu_valid = 1'b0;
        if (wr) gold[{a[31:2], 2'b00}] = d;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        int lat, wb0, fl0;
        logic [31:0] a, b, c;
        void'($urandom(32'd1234));
        a = 32'h0000_1230;            // index 0x123
        b = a + 32'h0000_4000;        // same index, next tag
        c = a + 32'h0000_8000;        // same index, third tag
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {127'd0, cpu_ready}, 128'd0, "cpu_ready after reset");
        chk("R1", {127'd0, mem_valid}, 128'd0, "mem_valid after reset");

        // clean miss after reset
        access(1'b0, a + 32'h4, 32'h0, rd, lat);
        chk("R1", 128'(n_fill), 128'd1, "first access fills");
        chk("R5", 128'(n_wb), 128'd0, "clean miss makes no write-back");
        chk("R5", {96'd0, last_fill_addr}, {96'd0, a}, "fill address");
        chk("R9", {96'd0, rd}, {96'd0, init_word(a + 32'h4)}, "read after refill");

        // read hit: two cycles, no memory traffic, word select by bits [3:2]
        fl0 = n_fill;
        access(1'b0, a + 32'hC, 32'h0, rd, lat);
        chk("R3", 128'(lat), 128'd2, "read hit latency");
        chk("R3", 128'(n_fill - fl0), 128'd0, "read hit no memory");
        chk("R2", {96'd0, rd}, {96'd0, init_word(a + 32'hC)}, "word select");

        // write hit
        access(1'b1, a + 32'h8, 32'hDEAD_BEEF, rd, lat);
        chk("R4", 128'(lat), 128'd2, "write hit latency");
        chk("R4", 128'(n_fill - fl0), 128'd0, "write hit no memory");
        access(1'b0, a + 32'h8, 32'h0, rd, lat);
        chk("R4", {96'd0, rd}, {96'd0, 32'hDEAD_BEEF}, "written word");
        access(1'b0, a + 32'h4, 32'h0, rd, lat);
        chk("R4", {96'd0, rd}, {96'd0, init_word(a + 32'h4)}, "neighbour word unchanged");

        // dirty miss: evict a, then refill b
        wb0 = n_wb; fl0 = n_fill;
        access(1'b0, b, 32'h0, rd, lat);
        chk("R6", 128'(n_wb - wb0), 128'd1, "one write-back");
        chk("R6", {96'd0, last_wb_addr}, {96'd0, a}, "victim address");
        chk("R6", 128'(wb_seq < fill_seq), 128'd1, "write-back before refill");
        chk("R9", {96'd0, rd}, {96'd0, init_word(b)}, "refilled word");

        // write miss on a clean line
        wb0 = n_wb; fl0 = n_fill;
        access(1'b1, c + 32'hC, 32'h1234_5678, rd, lat);
        chk("R5", 128'(n_wb - wb0), 128'd0, "clean write miss no write-back");
        chk("R5", 128'(n_fill - fl0), 128'd1, "clean write miss one fill");
        access(1'b0, c + 32'hC, 32'h0, rd, lat);
        chk("R9", {96'd0, rd}, {96'd0, 32'h1234_5678}, "write merged into refill");
        access(1'b0, c + 32'h8, 32'h0, rd, lat);
        chk("R9", {96'd0, rd}, {96'd0, init_word(c + 32'h8)}, "other refilled word");

        // evicted data returns from memory
        access(1'b0, a + 32'h8, 32'h0, rd, lat);
        chk("R6", {96'd0, last_wb_addr}, {96'd0, c}, "second victim address");
        chk("R6", {96'd0, rd}, {96'd0, 32'hDEAD_BEEF}, "round trip through memory");

        // random mix over few tags, lines and words
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            logic wr;
            ra = {16'($urandom % 4) << 2, 10'($urandom % 4) + 10'h3F0, 2'($urandom % 4), 2'b00};
            wr = 1'($urandom % 2);
            if (wr) begin
                access(1'b1, ra, $urandom, rd, lat);
            end else begin
                logic [31:0] exp;
                exp = gold_word(ra);
                access(1'b0, ra, 32'h0, rd, lat);
                chk("R3", {96'd0, rd}, {96'd0, exp}, "random read");
            end
        end
        done = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule